// File: doc/BRIEF.md
# Byte Serial Master with Automatic Select

This block is the master end of a four-wire synchronous serial link, one byte per transfer. Everything runs on the bus clock. A two-stage divider turns that clock into the serial clock. The first stage is a prescaler that divides by 1 to 8. The second stage is a power-of-two rate stage. A single start strobe does three things: it latches the transmit byte, it latches the clock format (idle polarity, phase, bit order), and it latches the divider fields. The block then shifts the byte out on the data output and collects eight bits from the data input.

When both the select-output enable and the fault-detect enable are 1 at start, the block drives an active-low select line by itself. The line falls as the transfer begins and rises half a serial-clock period after the eighth bit. In that same cycle the received byte is presented and a one-cycle done pulse is raised. Starts that arrive while the block is busy are ignored.

The controller has four states:
- IDLE: waiting for a start. A start while idle moves to XFER.
- XFER: sixteen serial-clock edges, one per half period. The sixteenth edge moves to TRAIL.
- TRAIL: one half period of trailing select. Its end moves to FINISH.
- FINISH: one cycle carrying the done pulse. It always returns to IDLE.

Top module: `spi_autosel_master`

## Requirements
- R1: After reset `ss_n_o` is 1, `busy_o` and `done_o` are 0. While idle, `sck_o` equals `cpol_i`.
- R2: The half period of the serial clock is H = (`presc_i`+1) × 2^`rate_i` bus cycles. The full period is therefore 2H.
- R3: A transfer produces exactly 16 serial-clock edges. The clock starts at, and returns to, the polarity latched at start.
- R4: With phase 0, the first bit is on `mosi_o` from the start of the transfer. `miso_i` is sampled on edges 1, 3, …, 15, and `mosi_o` advances on even edges.
- R5: With phase 1, `miso_i` is sampled on edges 2, 4, …, 16. `mosi_o` advances on odd edges from edge 3 onward.
- R6: `lsb_first_i`=1 sends and receives bit 0 first. `lsb_first_i`=0 sends and receives bit 7 first. `rx_data_o` holds each received bit at its proper weight.
- R7: When select is automatic, `ss_n_o` is low from the cycle after start is accepted. The first clock edge comes H cycles later. `ss_n_o` rises H cycles after the sixteenth edge, so it is low for 17H cycles.
- R8: If `ssoe_i` or `modf_en_i` is 0 at start, `ss_n_o` stays 1 for the whole transfer.
- R9: `done_o` is high for exactly one cycle, in the cycle `ss_n_o` rises, and `rx_data_o` is valid then. `busy_o` is high for 17H+1 cycles.
- R10: A start asserted while `busy_o` is 1 is ignored. The transfer in flight keeps its byte, and no second transfer follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cpol_i | input | 1 | Serial clock idle level |
| cpha_i | input | 1 | Clock phase: 0 samples on the first edge of a bit, 1 on the second |
| lsb_first_i | input | 1 | Bit order, 1 = bit 0 first |
| ssoe_i | input | 1 | Select output enable |
| modf_en_i | input | 1 | Fault-detect enable, also required for automatic select |
| presc_i | input | 3 | Prescale field, divisor = value+1 |
| rate_i | input | 3 | Rate field, divisor = 2^value per half period |
| start_i | input | 1 | Start strobe, accepted only when idle |
| tx_data_i | input | 8 | Byte to send |
| miso_i | input | 1 | Serial data in |
| sck_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data out |
| ss_n_o | output | 1 | Active-low select |
| rx_data_o | output | 8 | Byte received in the last transfer |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
A wrong edge counter or a stuck state shows at the ports within one transfer. It appears as an edge count other than 16, a select low time other than 17H, or a busy time other than 17H+1. A corrupted divider changes the measured half period at the very first pair of edges. A mis-steered sample or shift enable appears as a wrong received byte or a wrong bit seen on `mosi_o`, at the done pulse of the same transfer. An FSM that leaves FINISH late or re-enters XFER is caught the next cycle: done lasts two cycles, or busy stays high.

// File: rtl/spi_am_pkg.sv
package spi_am_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_XFER   = 2'd1,
        ST_TRAIL  = 2'd2,
        ST_FINISH = 2'd3
    } am_state_e;
endpackage

// File: rtl/spi_am_clkgen.sv
// Two-stage half-period tick generator: prescale (value+1), then 2^rate.
module spi_am_clkgen #(
    parameter int PRESC_W = 3,
    parameter int RATE_W  = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clear,
    input  logic [PRESC_W-1:0] presc,
    input  logic [RATE_W-1:0]  rate,
    output logic               tick
);
    localparam int RCNT_W = (1 << RATE_W) - 1;

    logic [PRESC_W-1:0] pcnt_q;
    logic [RCNT_W-1:0]  rcnt_q;
    logic [RCNT_W-1:0]  rate_lim;
    logic               pre_end;

    always_comb begin
        rate_lim = (RCNT_W'(1) << rate) - RCNT_W'(1);
        pre_end  = (pcnt_q == presc);
        tick     = pre_end && (rcnt_q == rate_lim);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pcnt_q <= '0;
            rcnt_q <= '0;
        end else if (clear) begin
            pcnt_q <= '0;
            rcnt_q <= '0;
        end else if (pre_end) begin
            pcnt_q <= '0;
            rcnt_q <= (rcnt_q == rate_lim) ? '0 : rcnt_q + RCNT_W'(1);
        end else begin
            pcnt_q <= pcnt_q + PRESC_W'(1);
        end
    end
endmodule

// File: rtl/spi_am_shifter.sv
// Transmit and receive shift registers with selectable bit order.
module spi_am_shifter #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] tx_byte,
    input  logic              lsb_first,
    input  logic              shift_en,
    input  logic              sample_en,
    input  logic              miso,
    output logic              mosi,
    output logic [DATA_W-1:0] rx_byte
);
    logic [DATA_W-1:0] tx_q;
    logic [DATA_W-1:0] rx_q;

    assign mosi    = lsb_first ? tx_q[0] : tx_q[DATA_W-1];
    assign rx_byte = rx_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_q <= '0;
            rx_q <= '0;
        end else if (load) begin
            tx_q <= tx_byte;
            rx_q <= '0;
        end else begin
            if (shift_en) begin
                tx_q <= lsb_first ? (tx_q >> 1) : (tx_q << 1);
            end
            if (sample_en) begin
                rx_q <= lsb_first ? {miso, rx_q[DATA_W-1:1]}
                                  : {rx_q[DATA_W-2:0], miso};
            end
        end
    end
endmodule

// File: rtl/spi_autosel_master.sv
module spi_autosel_master #(
    parameter int DATA_W  = 8,
    parameter int PRESC_W = 3,
    parameter int RATE_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpol_i,
    input  logic              cpha_i,
    input  logic              lsb_first_i,
    input  logic              ssoe_i,
    input  logic              modf_en_i,
    input  logic [PRESC_W-1:0] presc_i,
    input  logic [RATE_W-1:0] rate_i,
    input  logic              start_i,
    input  logic [DATA_W-1:0] tx_data_i,
    input  logic              miso_i,
    output logic              sck_o,
    output logic              mosi_o,
    output logic              ss_n_o,
    output logic [DATA_W-1:0] rx_data_o,
    output logic              busy_o,
    output logic              done_o
);
    import spi_am_pkg::*;

    localparam int EDGES = 2 * DATA_W;
    localparam int EC_W  = $clog2(EDGES + 1);

    am_state_e          st_q, st_d;
    logic [EC_W-1:0]    ec_q;
    logic               ph_q;
    logic               cpol_q, cpha_q, lsb_q, auto_q;
    logic [PRESC_W-1:0] presc_q;
    logic [RATE_W-1:0]  rate_q;
    logic [DATA_W-1:0]  rx_q;
    logic [DATA_W-1:0]  sh_rx;
    logic               tick, accept, xtick, edge_odd, last_edge;
    logic               sample_en, shift_en, div_clear, sh_mosi;

    assign accept    = (st_q == ST_IDLE) && start_i;
    assign xtick     = (st_q == ST_XFER) && tick;
    assign edge_odd  = ~ec_q[0];
    assign last_edge = (ec_q == EC_W'(EDGES - 1));
    assign sample_en = xtick && (cpha_q ? ~edge_odd : edge_odd);
    assign shift_en  = xtick && (cpha_q ? (edge_odd && (ec_q != '0)) : ~edge_odd);
    assign div_clear = ~((st_q == ST_XFER) || (st_q == ST_TRAIL));

    spi_am_clkgen #(.PRESC_W(PRESC_W), .RATE_W(RATE_W)) clkgen_i (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (div_clear),
        .presc (presc_q),
        .rate  (rate_q),
        .tick  (tick)
    );

    spi_am_shifter #(.DATA_W(DATA_W)) shifter_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (accept),
        .tx_byte   (tx_data_i),
        .lsb_first (lsb_q),
        .shift_en  (shift_en),
        .sample_en (sample_en),
        .miso      (miso_i),
        .mosi      (sh_mosi),
        .rx_byte   (sh_rx)
    );

    // Next-state logic
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:   if (start_i) st_d = ST_XFER;
            ST_XFER:   if (tick && last_edge) st_d = ST_TRAIL;
            ST_TRAIL:  if (tick) st_d = ST_FINISH;
            ST_FINISH: st_d = ST_IDLE;
            default:   st_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // Configuration, edge counter, clock phase and received byte
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ec_q    <= '0;
            ph_q    <= 1'b0;
            cpol_q  <= 1'b0;
            cpha_q  <= 1'b0;
            lsb_q   <= 1'b0;
            auto_q  <= 1'b0;
            presc_q <= '0;
            rate_q  <= '0;
            rx_q    <= '0;
        end else begin
            if (accept) begin
                ec_q    <= '0;
                ph_q    <= 1'b0;
                cpol_q  <= cpol_i;
                cpha_q  <= cpha_i;
                lsb_q   <= lsb_first_i;
                auto_q  <= ssoe_i & modf_en_i;
                presc_q <= presc_i;
                rate_q  <= rate_i;
            end
            if (xtick) begin
                ec_q <= ec_q + EC_W'(1);
                ph_q <= ~ph_q;
            end
            if ((st_q == ST_TRAIL) && tick) begin
                rx_q <= sh_rx;
            end
        end
    end

    // Outputs
    always_comb begin
        busy_o    = (st_q != ST_IDLE);
        done_o    = (st_q == ST_FINISH);
        ss_n_o    = ~(auto_q && ((st_q == ST_XFER) || (st_q == ST_TRAIL)));
        sck_o     = (st_q == ST_IDLE) ? cpol_i : (cpol_q ^ ph_q);
        mosi_o    = sh_mosi;
        rx_data_o = rx_q;
    end
endmodule

// File: rtl/spi_am_checker.sv
module spi_am_checker (
    input logic clk,
    input logic rst_n,
    input logic start_i,
    input logic ss_n_o,
    input logic busy_o,
    input logic done_o
);
    // R8: select is only low inside a transfer
    p_ss_within_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !ss_n_o |-> busy_o);

    // R9: done lasts one cycle and the block is idle right after
    p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    p_idle_after_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !busy_o);
    p_done_ss_high_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> ss_n_o);

    // R7: select rises only with completion, falls only after a start
    p_ss_rise_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ss_n_o) |-> done_o);
    p_ss_fall_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ss_n_o) |-> $past(start_i));

    // R10: a start during a transfer does not end or restart it
    p_busy_ignores_start_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !done_o && start_i) |=> busy_o);
endmodule

bind spi_autosel_master spi_am_checker chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_i),
    .ss_n_o  (ss_n_o),
    .busy_o  (busy_o),
    .done_o  (done_o)
);

// File: tb/spi_autosel_master_tb_top.sv
`timescale 1ns/1ps
module spi_autosel_master_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cpol_i = 1'b0, cpha_i = 1'b0, lsb_first_i = 1'b0;
    logic       ssoe_i = 1'b1, modf_en_i = 1'b1;
    logic [2:0] presc_i = '0, rate_i = '0;
    logic       start_i = 1'b0;
    logic [7:0] tx_data_i = '0;
    logic       miso_i = 1'b0;
    logic       sck_o, mosi_o, ss_n_o, busy_o, done_o;
    logic [7:0] rx_data_o;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    spi_autosel_master dut_i (
        .clk(clk), .rst_n(rst_n), .cpol_i(cpol_i), .cpha_i(cpha_i),
        .lsb_first_i(lsb_first_i), .ssoe_i(ssoe_i), .modf_en_i(modf_en_i),
        .presc_i(presc_i), .rate_i(rate_i), .start_i(start_i),
        .tx_data_i(tx_data_i), .miso_i(miso_i), .sck_o(sck_o),
        .mosi_o(mosi_o), .ss_n_o(ss_n_o), .rx_data_o(rx_data_o),
        .busy_o(busy_o), .done_o(done_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic pick(input logic [7:0] b, input bit lsb, input int k);
        return lsb ? b[k] : b[7-k];
    endfunction

    task automatic test_reset();
        chk(ss_n_o == 1'b1, "R1 ss_n after reset", ss_n_o, 1);
        chk(busy_o == 1'b0, "R1 busy after reset", busy_o, 0);
        chk(done_o == 1'b0, "R1 done after reset", done_o, 0);
        cpol_i = 1'b1;
        #1;
        chk(sck_o == 1'b1, "R1 idle sck follows cpol=1", sck_o, 1);
        cpol_i = 1'b0;
        #1;
        chk(sck_o == 1'b0, "R1 idle sck follows cpol=0", sck_o, 0);
    endtask

    task automatic xfer(input bit pol, input bit pha, input bit lsb, input bit soe,
                        input bit mfe, input int pre, input int rt,
                        input logic [7:0] tx, input logic [7:0] sl, input bit inject);
        int h, n, edges, si, busycnt, sslow, dones;
        int first_n, second_n, last_n, rise_n;
        logic prev_sck, prev_ss;
        logic [7:0] got, rxgot;
        h = (pre + 1) << rt;
        edges = 0; si = 0; busycnt = 0; sslow = 0; dones = 0;
        first_n = -1; second_n = -1; last_n = -1; rise_n = -1;
        got = '0; rxgot = '0;
        @(negedge clk);
        cpol_i = pol; cpha_i = pha; lsb_first_i = lsb; ssoe_i = soe; modf_en_i = mfe;
        presc_i = 3'(pre); rate_i = 3'(rt); tx_data_i = tx;
        miso_i = pick(sl, lsb, 0);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        chk(sck_o == pol, "R3 clock starts at polarity", sck_o, pol);
        prev_sck = sck_o;
        prev_ss = 1'b0;
        n = 0;
        while (busy_o && n < 40000) begin
            if (inject && n == 3) begin start_i = 1'b1; tx_data_i = ~tx; end
            if (inject && n == 4) start_i = 1'b0;
            busycnt++;
            if (!ss_n_o) sslow++;
            if (ss_n_o && !prev_ss && n > 0) rise_n = n;
            prev_ss = ss_n_o;
            if (sck_o != prev_sck) begin
                edges++;
                if (edges == 1) first_n = n;
                if (edges == 2) second_n = n;
                last_n = n;
                if ((pha ? (edges % 2 == 0) : (edges % 2 == 1))) begin
                    int k;
                    k = pha ? (edges / 2 - 1) : ((edges - 1) / 2);
                    if (lsb) got[k] = mosi_o; else got[7-k] = mosi_o;
                end
                if ((pha ? (edges % 2 == 1 && edges > 1) : (edges % 2 == 0))) begin
                    si++;
                    if (si < 8) miso_i = pick(sl, lsb, si);
                end
            end
            prev_sck = sck_o;
            if (done_o) begin
                dones++;
                rxgot = rx_data_o;
                chk(ss_n_o == 1'b1, "R9 select high at done", ss_n_o, 1);
            end
            @(negedge clk);
            n++;
        end
        chk(edges == 16, "R3 edge count", edges, 16);
        chk(sck_o == pol, "R3 clock back at polarity", sck_o, pol);
        chk(second_n - first_n == h, "R2 half period", second_n - first_n, h);
        chk(got == tx, pha ? "R5/R6 bits seen on mosi" : "R4/R6 bits seen on mosi", got, tx);
        chk(rxgot == sl, pha ? "R5/R6 received byte" : "R4/R6 received byte", rxgot, sl);
        chk(dones == 1, "R9 done pulse count", dones, 1);
        chk(busycnt == 17 * h + 1, "R9 busy length", busycnt, 17 * h + 1);
        if (soe && mfe) begin
            chk(sslow == 17 * h, "R7 select low length", sslow, 17 * h);
            chk(first_n == h, "R7 lead before first edge", first_n, h);
            chk(rise_n - last_n == h, "R7 trail after last edge", rise_n - last_n, h);
        end else begin
            chk(sslow == 0, "R8 select stays high", sslow, 0);
        end
        if (inject) begin
            repeat (3) @(negedge clk);
            chk(busy_o == 1'b0, "R10 no second transfer", busy_o, 0);
        end
    endtask

    task automatic test_mode0();   xfer(0, 0, 0, 1, 1, 0, 0, 8'hA5, 8'h3C, 0); endtask
    task automatic test_mode2lsb(); xfer(1, 0, 1, 1, 1, 2, 1, 8'h81, 8'h6E, 0); endtask
    task automatic test_mode1();   xfer(0, 1, 0, 1, 1, 0, 2, 8'h5B, 8'hC3, 0); endtask
    task automatic test_mode3lsb(); xfer(1, 1, 1, 1, 1, 7, 0, 8'h0F, 8'hF1, 0); endtask
    task automatic test_no_auto_a(); xfer(0, 0, 0, 1, 0, 1, 0, 8'h33, 8'h99, 0); endtask
    task automatic test_no_auto_b(); xfer(0, 1, 1, 0, 1, 0, 1, 8'hE4, 8'h27, 0); endtask
    task automatic test_busy_start(); xfer(0, 0, 0, 1, 1, 1, 1, 8'hC6, 8'h5A, 1); endtask
    task automatic test_slowest();  xfer(1, 0, 0, 1, 1, 7, 7, 8'h7E, 8'hB2, 0); endtask

    initial begin
        repeat (3) @(negedge clk);
        test_reset();
        rst_n = 1'b1;
        @(negedge clk);
        test_reset();
        test_mode0();
        test_mode2lsb();
        test_mode1();
        test_mode3lsb();
        test_no_auto_a();
        test_no_auto_b();
        test_busy_start();
        test_slowest();
        if (!finished) begin
            finished = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule